// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block sits between the synthesized clocks of a multi-output clock generator and its output pins. It stops every output cleanly when power-down is requested, asks for the oscillator and PLL to be switched off once every output is parked, and brings the outputs back in an orderly way when the request is withdrawn and the PLL reports lock. Single-ended outputs are parked low. Each differential pair is parked either with the true pin driven high and the complement pin released, or with both pins released. The choice is made per pair by a drive-mode bit. Tri-state is modelled as an output-enable per pin.

The control input pin has two roles. Right after reset it is an active-low power-good signal, and the block keeps everything parked. Once the pin has been seen low, it becomes an active-high power-down request. The pin is asynchronous. It is synchronized on the rising edge of the reference complement clock, which is the complement input of differential pair 0. A request is honoured only after two consecutive synchronized samples are high. Each output is gated by a flop clocked on the falling edge of its own clock, so it stops and restarts only during its low phase.

There is no data stream in this block, so every pin is a plain control or clock signal without valid/ready handshaking. `pll_lock` is taken as synchronous to the reference complement clock.

Top module: `clkout_pd_seq`

## Requirements
- R1: From reset until the pin has been seen low after synchronization, every output is parked and `osc_pd` is 1. A high pin and `pll_lock` have no power-up effect in this phase.
- R2: Once the pin has been seen low, the power-up sequence starts (`osc_pd` falls). From then on, a high pin is a power-down request.
- R3: The pin passes through a two-flop synchronizer clocked by the rising edge of `df_c_in[0]`. A request is recognised only when two consecutive synchronized samples are high. A high pulse that covers just one such edge leaves every output running.
- R4: After recognition, each single-ended output is held low from the next falling edge of its own input clock, and its high phase is never cut short.
- R5: Each differential pair stops on the next falling edge of its complement input. When parked with `drive_mode` bit 0, the true pin is enabled and driven 1 and the complement enable is 0. When parked with bit 1, both enables are 0.
- R6: `osc_pd` rises only after every output has acknowledged its stop through a synchronizer. While `osc_pd` is 1, all single-ended outputs are 0 and all complement enables are 0.
- R7: After `osc_pd` falls and before the outputs restart, every true pin is enabled and driven 1, every complement enable is 0, and every single-ended output is 0.
- R8: Outputs are granted RELOCK_CYC reference cycles after `pll_lock` is first sampled high (a low sample restarts the count). Each output then restarts on its own falling edge. With RELOCK_CYC=2, `se_out[0]` is still low in the two clock periods that follow the lock edge and is toggling in the third.
- R9: While running, every output follows its input clock, all enables are 1, and `osc_pd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pgpd_pin | input | 1 | Dual-role pin: active-low power-good, then active-high power-down |
| se_in | input | N_SE | Single-ended clocks from the synthesizer |
| df_t_in | input | N_DF | Differential true clocks |
| df_c_in | input | N_DF | Differential complement clocks; bit 0 is the reference |
| drive_mode | input | N_DF | Per-pair park mode: 0 = true high, 1 = both released |
| pll_lock | input | 1 | PLL lock indication, synchronous to reference |
| se_out | output | N_SE | Gated single-ended clocks |
| df_t_out | output | N_DF | Differential true output values |
| df_c_out | output | N_DF | Differential complement output values |
| df_t_oe | output | N_DF | Output enable for each true pin |
| df_c_oe | output | N_DF | Output enable for each complement pin |
| osc_pd | output | 1 | Request to power the oscillator and PLL down |

## Verification
The bench uses the defaults N_SE=3, N_DF=2, RELOCK_CYC=2 and SYNC_STAGES=2. The single-ended clocks run at full, half and quarter rate, and the second pair runs at half rate, so each output reaches its falling edge at a different time. This shows that stops and restarts really follow each output's own clock, and that the park acknowledge waits for the slowest output. With a relock count of 2, the bench can predict the exact clock period in which the fastest output restarts. With a two-stage synchronizer, a pin pulse exactly one or two reference edges wide falls on either side of the recognition threshold.

// File: rtl/clkout_pd_pkg.sv
package clkout_pd_pkg;
  typedef enum logic [2:0] {
    ST_PARK  = 3'd0,
    ST_WAKE  = 3'd1,
    ST_START = 3'd2,
    ST_RUN   = 3'd3,
    ST_STOP  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/clkout_pd_pinsync.sv
// Dual-role pin capture in the reference domain.
module clkout_pd_pinsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pin,
  output logic pg_seen,
  output logic pd_det,
  output logic stop_req
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   synced;
  logic                   prev_q;

  // R3: resets to "pin high" so no low level is invented at reset
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[SYNC_STAGES-2:0], pin};
  end

  assign synced = chain[LAST];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pg_seen <= 1'b0;
    end else begin
      prev_q  <= synced;
      pg_seen <= pg_seen | ~synced;   // R1/R2: role switch is sticky
    end
  end

  // R3: two consecutive synchronized high samples
  assign pd_det   = pg_seen & synced & prev_q;
  assign stop_req = ~pg_seen | pd_det;
endmodule

// File: rtl/clkout_pd_gate_se.sv
// Glitch-free gate for one single-ended clock.
module clkout_pd_gate_se (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run_req,
  output logic clk_out,
  output logic en_out
);
  logic en_q;

  // R4/R8: enable changes only while clk_in is low
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run_req;
  end

  assign clk_out = clk_in & en_q;
  assign en_out  = en_q;
endmodule

// File: rtl/clkout_pd_gate_df.sv
// Gate and park logic for one differential pair.
module clkout_pd_gate_df (
  input  logic t_in,
  input  logic c_in,
  input  logic rst_n,
  input  logic run_req,
  input  logic drive_mode,
  input  logic wake_hi,
  output logic t_out,
  output logic c_out,
  output logic t_oe,
  output logic c_oe,
  output logic en_out
);
  logic en_q;

  // R5: stop on the complement's falling edge (true pin is rising there)
  always_ff @(negedge c_in or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run_req;
  end

  assign t_out  = en_q ? t_in : 1'b1;
  assign c_out  = en_q ? c_in : 1'b0;
  // R5 park mode, R7 true pins driven high during wake
  assign t_oe   = en_q | ~drive_mode | wake_hi;
  assign c_oe   = en_q;
  assign en_out = en_q;
endmodule

// File: rtl/clkout_pd_ctrl.sv
// Sequencer: stop, park, wake, relock wait, start, run.
module clkout_pd_ctrl
  import clkout_pd_pkg::*;
#(
  parameter int N_GATE     = 5,
  parameter int RELOCK_CYC = 2,
  parameter int ACK_STAGES = 2
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              pll_lock,
  input  logic [N_GATE-1:0] gate_en,
  output logic              run_req,
  output logic              wake_hi,
  output logic              osc_pd
);
  localparam int              CNT_W    = (RELOCK_CYC > 1) ? $clog2(RELOCK_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELOCK_CYC - 1);

  seq_st_t                st;
  logic [CNT_W-1:0]       cnt;
  logic [ACK_STAGES-1:0]  park_sh;
  logic [ACK_STAGES-1:0]  run_sh;
  logic                   parked_s;
  logic                   running_s;

  // R6: gate acknowledgements brought into the reference domain
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      park_sh <= '1;
      run_sh  <= '0;
    end else begin
      park_sh <= {park_sh[ACK_STAGES-2:0], ~|gate_en};
      run_sh  <= {run_sh[ACK_STAGES-2:0], &gate_en};
    end
  end

  assign parked_s  = park_sh[ACK_STAGES-1];
  assign running_s = run_sh[ACK_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_PARK;
      cnt <= '0;
    end else begin
      case (st)
        ST_PARK: begin
          cnt <= '0;
          if (!stop_req) st <= ST_WAKE;
        end
        ST_WAKE: begin
          if (stop_req) begin
            st  <= ST_STOP;
            cnt <= '0;
          end else if (pll_lock) begin
            if (cnt == CNT_LAST) begin     // R8
              st  <= ST_START;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            cnt <= '0;
          end
        end
        // start finishes before a stop so no stale park acknowledge is seen
        ST_START: if (running_s) st <= ST_RUN;
        ST_RUN:   if (stop_req)  st <= ST_STOP;
        ST_STOP:  if (parked_s)  st <= ST_PARK;
        default:  st <= ST_PARK;
      endcase
    end
  end

  assign run_req = (st == ST_START) || (st == ST_RUN);
  assign wake_hi = (st == ST_WAKE) || (st == ST_START);
  assign osc_pd  = (st == ST_PARK);
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
  import clkout_pd_pkg::*;
#(
  parameter int N_SE        = 3,
  parameter int N_DF        = 2,
  parameter int RELOCK_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic            pgpd_pin,
  input  logic [N_SE-1:0] se_in,
  input  logic [N_DF-1:0] df_t_in,
  input  logic [N_DF-1:0] df_c_in,
  input  logic [N_DF-1:0] drive_mode,
  input  logic            pll_lock,
  output logic [N_SE-1:0] se_out,
  output logic [N_DF-1:0] df_t_out,
  output logic [N_DF-1:0] df_c_out,
  output logic [N_DF-1:0] df_t_oe,
  output logic [N_DF-1:0] df_c_oe,
  output logic            osc_pd
);
  localparam int N_GATE = N_SE + N_DF;

  logic            ref_clk;
  logic            pg_seen;
  logic            pd_det;
  logic            stop_req;
  logic            run_req;
  logic            wake_hi;
  logic [N_SE-1:0] se_en;
  logic [N_DF-1:0] df_en;

  assign ref_clk = df_c_in[0];

  clkout_pd_pinsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .pin      (pgpd_pin),
    .pg_seen  (pg_seen),
    .pd_det   (pd_det),
    .stop_req (stop_req)
  );

  clkout_pd_ctrl #(
    .N_GATE     (N_GATE),
    .RELOCK_CYC (RELOCK_CYC),
    .ACK_STAGES (2)
  ) u_ctrl (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .pll_lock (pll_lock),
    .gate_en  ({df_en, se_en}),
    .run_req  (run_req),
    .wake_hi  (wake_hi),
    .osc_pd   (osc_pd)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    clkout_pd_gate_se u_gate (
      .clk_in  (se_in[i]),
      .rst_n   (rst_n),
      .run_req (run_req),
      .clk_out (se_out[i]),
      .en_out  (se_en[i])
    );
  end

  for (genvar j = 0; j < N_DF; j++) begin : g_df
    clkout_pd_gate_df u_gate (
      .t_in       (df_t_in[j]),
      .c_in       (df_c_in[j]),
      .rst_n      (rst_n),
      .run_req    (run_req),
      .drive_mode (drive_mode[j]),
      .wake_hi    (wake_hi),
      .t_out      (df_t_out[j]),
      .c_out      (df_c_out[j]),
      .t_oe       (df_t_oe[j]),
      .c_oe       (df_c_oe[j]),
      .en_out     (df_en[j])
    );
  end
endmodule

// File: rtl/clkout_pd_chk.sv
module clkout_pd_chk #(
  parameter int N_SE = 3,
  parameter int N_DF = 2
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            pg_seen,
  input logic            pd_det,
  input logic            run_req,
  input logic            osc_pd,
  input logic            pll_lock,
  input logic [N_DF-1:0] drive_mode,
  input logic [N_SE-1:0] se_out,
  input logic [N_DF-1:0] df_t_out,
  input logic [N_DF-1:0] df_t_oe,
  input logic [N_DF-1:0] df_c_oe
);
  a_r1_parked_before_pg: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pg_seen |-> osc_pd);

  a_r3_stop_needs_two_samples: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(run_req) |-> $past(pd_det));

  a_r6_off_only_when_parked: assert property (@(posedge ref_clk) disable iff (!rst_n)
    osc_pd |-> (se_out == '0) && (df_c_oe == '0));

  a_r5_park_mode: assert property (@(posedge ref_clk) disable iff (!rst_n)
    osc_pd |-> ((df_t_oe & drive_mode) == '0) &&
               (((df_t_oe & df_t_out) | drive_mode) == '1));

  a_r7_wake_true_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(osc_pd) |-> (df_t_oe == '1) && (df_t_out == '1) && (df_c_oe == '0));

  a_r8_grant_after_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(run_req) |-> $past(pll_lock));
endmodule

bind clkout_pd_seq clkout_pd_chk #(.N_SE(N_SE), .N_DF(N_DF)) u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .pg_seen    (pg_seen),
  .pd_det     (pd_det),
  .run_req    (run_req),
  .osc_pd     (osc_pd),
  .pll_lock   (pll_lock),
  .drive_mode (drive_mode),
  .se_out     (se_out),
  .df_t_out   (df_t_out),
  .df_t_oe    (df_t_oe),
  .df_c_oe    (df_c_oe)
);

// File: tb/clkout_pd_seq_test.sv
module clkout_pd_seq_test;
  localparam int K_RUN  = 0;
  localparam int K_PARK = 1;
  localparam int K_WAKE = 2;

  logic       clk = 1'b0;
  logic [1:0] div = 2'b00;
  logic       rst_n = 1'b0;
  logic       pgpd_pin = 1'b1;
  logic       pll_lock = 1'b0;
  logic [1:0] drive_mode = 2'b00;
  logic [2:0] se_in;
  logic [1:0] df_t_in, df_c_in;
  logic [2:0] se_out;
  logic [1:0] df_t_out, df_c_out, df_t_oe, df_c_oe;
  logic       osc_pd;

  int total = 0;
  int bad = 0;
  int r6_viol = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;

  assign se_in   = {div[1], div[0], clk};
  assign df_t_in = {div[0], clk};
  assign df_c_in = ~df_t_in;

  clkout_pd_seq uut (
    .rst_n(rst_n), .pgpd_pin(pgpd_pin), .se_in(se_in), .df_t_in(df_t_in),
    .df_c_in(df_c_in), .drive_mode(drive_mode), .pll_lock(pll_lock),
    .se_out(se_out), .df_t_out(df_t_out), .df_c_out(df_c_out),
    .df_t_oe(df_t_oe), .df_c_oe(df_c_oe), .osc_pd(osc_pd)
  );

  // sig layout: [2:0] se, [4:3] t_out, [6:5] c_out, [8:7] t_oe, [10:9] c_oe, [11] osc_pd
  function automatic logic [11:0] exp_sig(int k, logic [1:0] m, logic [2:0] si,
                                          logic [1:0] ti, logic [1:0] ci);
    if (k == K_RUN)       return {1'b0, 2'b11, 2'b11, ci, ti, si};
    else if (k == K_PARK) return {1'b1, 2'b00, ~m, 2'b00, 2'b11, 3'b000};
    else                  return {1'b0, 2'b00, 2'b11, 2'b00, 2'b11, 3'b000};
  endfunction

  function automatic logic [11:0] exp_mask(int k, logic [1:0] m);
    if (k == K_RUN)       return 12'hFFF;
    else if (k == K_PARK) return {1'b1, 2'b11, 2'b11, 2'b00, ~m, 3'b111};
    else                  return {1'b1, 2'b11, 2'b11, 2'b00, 2'b11, 3'b111};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic observe(input int k, input int n, input string req);
    logic [11:0] a, e, m;
    logic [11:0] fa, fe;
    bit ok;
    ok = 1; fa = '0; fe = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      a = {osc_pd, df_c_oe, df_t_oe, df_c_out, df_t_out, se_out};
      e = exp_sig(k, drive_mode, se_in, df_t_in, df_c_in);
      m = exp_mask(k, drive_mode);
      if (((a ^ e) & m) != 0 && ok) begin
        ok = 0; fa = a & m; fe = e & m;
      end
    end
    chk(ok, req, 32'(fa), 32'(fe));
  endtask

  task automatic wait_osc(input logic v, input int maxc, input string req);
    int n;
    n = 0;
    while (osc_pd !== v && n < maxc) begin
      @(posedge clk); #2; n++;
    end
    chk(osc_pd === v, req, 32'(osc_pd), 32'(v));
  endtask

  // pin low, wake with lock low, then lock and exact restart timing
  task automatic power_up();
    @(posedge clk); #1; pgpd_pin = 1'b0;
    wait_osc(1'b0, 20, "R2 osc_pd released after pin low");
    observe(K_WAKE, 3, "R7 wake: true pins high, complements released");
    @(posedge clk); #1; pll_lock = 1'b1;
    @(posedge clk); #2;
    chk(se_out[0] == 1'b0, "R8 no output one period after lock", 32'(se_out[0]), 0);
    @(posedge clk); #2;
    chk(se_out[0] == 1'b0, "R8 no output two periods after lock", 32'(se_out[0]), 0);
    @(posedge clk); #2;
    chk(se_out[0] == 1'b1, "R8 fastest output restarted in third period", 32'(se_out[0]), 1);
    repeat (8) @(posedge clk);
    observe(K_RUN, 8, "R9 all outputs running");
  endtask

  task automatic power_down(input logic [1:0] m);
    @(posedge clk); #1; drive_mode = m; pgpd_pin = 1'b1;
    repeat (20) @(posedge clk);
    observe(K_PARK, 6, "R4 R5 R6 outputs parked per drive mode");
    @(posedge clk); #1; pll_lock = 1'b0;
  endtask

  // pin high for exactly len reference edges
  task automatic pulse(input int len);
    @(posedge clk); #1; pgpd_pin = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
    end
    pgpd_pin = 1'b0;
    if (len >= 2) pll_lock = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && osc_pd && (se_out != 3'b000 || df_c_oe != 2'b00)) r6_viol++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    drive_mode = 2'b01;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    observe(K_PARK, 4, "R1 reset state parked");
    repeat (10) @(posedge clk);
    observe(K_PARK, 4, "R1 pin high before power-good keeps parked");
    @(posedge clk); #1; pll_lock = 1'b1;
    repeat (10) @(posedge clk);
    observe(K_PARK, 4, "R1 lock before power-good has no effect");
    @(posedge clk); #1; pll_lock = 1'b0;

    power_up();

    // directed: one-edge pulse ignored, two-edge pulse recognised
    pulse(1);
    observe(K_RUN, 12, "R3 single-sample pulse ignored");
    pulse(2);
    wait_osc(1'b1, 40, "R3 two-sample pulse recognised");
    power_up();

    power_down(2'b00);
    power_up();
    power_down(2'b11);
    power_up();

    for (int r = 0; r < 8; r++) begin
      int len;
      len = $urandom_range(1, 4);
      if (len == 1) begin
        pulse(1);
        observe(K_RUN, 10, "R3 random single-sample pulse ignored");
      end else if (len < 4) begin
        pulse(len);
        wait_osc(1'b1, 40, "R3 random pulse recognised");
        power_up();
      end else begin
        power_down(2'($urandom_range(0, 3)));
        power_up();
      end
    end

    chk(r6_viol == 0, "R6 osc_pd never seen with outputs active", 32'(r6_viol), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule